// File: doc/BRIEF.md
# Full-Frame Sensor Readout Sequencer with Row Window

This block runs the readout of one full frame from a full-frame image sensor. A start pulse begins an exposure of programmable length. Then the block runs one serial clear-out pass and walks every row of the array from the top in ascending order. A row inside the configured window is moved into the serial register by a vertical transfer and then read out by a serial line pass. A row outside the window is dropped by a single vertical sequence. During that sequence the serial phases are parked high, so the charge spills into the lateral drain and no serial readout is spent on it. The serial register cannot be fully emptied this way. So after any run of dropped rows, one serial flush pass is run and its data is discarded before the next valid line.

The block does not generate clock waveforms itself. It issues one-cycle start pulses, with mode qualifiers, to a vertical sequencer and a serial line generator, and it waits for their one-cycle done pulses. Optional 2x vertical binning moves two window rows into the serial register before each line read, which halves the number of output lines. In low-dark-current mode the block also tells the vertical driver to hold every vertical phase low for the whole exposure. Each valid output line is tagged with the index of its first row. A start that arrives during a frame is ignored. An abort takes effect once the running sub-sequence has completed.

Top module: `ccd_frame_seq`

## Requirements
- R1: After an accepted start, `integ_o` is high for exactly max(N,1) consecutive cycles, where N is `cfg_integ_len_i` sampled at start. `vclk_low_o` is high in exactly those cycles when `cfg_lowdark_i` was 1 at start, and never otherwise.
- R2: The first sub-sequence after the exposure is a serial pass with `sseq_clear_o`=1. It is issued in the cycle after `integ_o` falls.
- R3: Rows 0 to ROWS-1 are handled in ascending order. Each row gets exactly one vertical sequence. The full sequence of issued pulses matches the order that R4 to R7 define.
- R4: A row r with r < first or r > last (first = `cfg_row_first_i`, last = `cfg_row_last_i`) gets one vertical sequence with `ser_park_o`=1 from its go pulse until its done. It gets no serial pass of its own and produces no line.
- R5: If one or more rows were dropped since the last serial pass, a serial pass with `sseq_clear_o`=1 runs before the next in-window vertical transfer. It produces no line.
- R6: Without binning, each in-window row gets a vertical transfer (`ser_park_o`=0) followed by a serial read (`sseq_clear_o`=0). `line_valid_o` pulses for one cycle, in the cycle after the read's done, with `line_row_o` equal to the row index.
- R7: With `cfg_bin2_i`=1, window rows are grouped in pairs starting at first. Each pair gets two vertical transfers and then one read, tagged with the pair's first row. A last row left without a partner is read alone.
- R8: `frame_done_o` pulses for one cycle after the last row's final sub-sequence completes. `busy_o` is low from the next cycle on.
- R9: A start pulse while `busy_o` is high has no effect: the frame runs unchanged, and no second frame follows.
- R10: An abort lets the running sub-sequence finish. After that the block issues no further go pulse, returns to idle and gives no `frame_done_o`.
- R11: After reset every output is low.
- R12: `vseq_go_o` and `sseq_go_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a frame (accepted only when idle) |
| abort_i | input | 1 | Stop the frame after the current sub-sequence |
| cfg_row_first_i | input | ROW_W | First row of the window |
| cfg_row_last_i | input | ROW_W | Last row of the window |
| cfg_bin2_i | input | 1 | 1 = 2x vertical binning |
| cfg_lowdark_i | input | 1 | 1 = hold vertical phases low during exposure |
| cfg_integ_len_i | input | INT_W | Exposure length in cycles |
| vseq_done_i | input | 1 | Vertical sequencer finished |
| sseq_done_i | input | 1 | Serial generator finished |
| integ_o | output | 1 | Exposure in progress |
| vclk_low_o | output | 1 | Hold all vertical phases low |
| vseq_go_o | output | 1 | Start one vertical sequence |
| ser_park_o | output | 1 | Park serial phases high (row drop) |
| sseq_go_o | output | 1 | Start one serial pass |
| sseq_clear_o | output | 1 | Serial pass is a clear/flush, data invalid |
| line_valid_o | output | 1 | A valid line was read |
| line_row_o | output | ROW_W | Row index of that line |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | Frame completed |

## Verification
The bench targets the edges of the window: a window that starts at row 0, so no flush is needed after the clear-out; a window that ends at the last row; a window holding one row; and an empty window with first > last, where every row is dropped. A design that forgot the flush after dropped rows would issue a vertical transfer straight after a parked one, and the compared pulse order would differ. Binning over an odd-sized window checks that the leftover row is read alone with the right tag; a pairing bug shows up as a wrong line count or a wrong tag. A start injected mid-frame and aborts during the exposure and during the row walk check that a design which restarts, or which keeps issuing pulses after an abort, is caught through extra go pulses or a stray frame-done.

// File: rtl/ccd_seq_pkg.sv
// Shared types of the frame readout sequencer.
package ccd_seq_pkg;
    // Top-level sequencing states; *_GO states issue a pulse, *_WAIT wait for done.
    typedef enum logic [3:0] {
        ST_IDLE, ST_INTEG, ST_CLR_GO, ST_CLR_WAIT, ST_ROW,
        ST_DUMP_GO, ST_DUMP_WAIT, ST_FLUSH_GO, ST_FLUSH_WAIT,
        ST_XFER_GO, ST_XFER_WAIT, ST_READ_GO, ST_READ_WAIT, ST_FIN
    } seq_state_t;
endpackage

// File: rtl/ccd_integ_timer.sv
// Exposure timer. Loaded with a length, it counts down while run is high.
// expired is high when at most one cycle is left, so an exposure state that
// leaves on expired lasts max(len,1) cycles.
// Assumes: load and run are never high together.
module ccd_integ_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load or count down the remaining exposure cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (run && cnt > CNT_W'(1))
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt <= CNT_W'(1));
endmodule

// File: rtl/ccd_row_track.sv
// Row pointer and window decode. Clears to row 0 and advances by one on adv.
// Reports whether the current row is in the window, whether it is the final
// array row, and whether a binning partner row exists after it.
// Assumes: adv is never raised on the final row.
module ccd_row_track #(
    parameter int ROWS  = 330,
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [ROW_W-1:0] first,
    input  logic [ROW_W-1:0] last,
    output logic [ROW_W-1:0] row,
    output logic             in_win,
    output logic             at_end,
    output logic             pair_ok
);
    localparam logic [ROW_W-1:0] END_ROW = ROW_W'(ROWS - 1);

    // Hold the index of the row being handled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            row <= '0;
        else if (adv)
            row <= row + ROW_W'(1);
    end

    // Window and boundary decode of the current row.
    always_comb begin
        in_win  = (row >= first) && (row <= last);
        at_end  = (row == END_ROW);
        pair_ok = (row < last) && !at_end;
    end
endmodule

// File: rtl/ccd_frame_seq.sv
// Frame readout sequencer. Runs exposure, a serial clear-out, then for each row
// either a drop (vertical sequence with serial phases parked) or a transfer
// plus a serial line read, with an invalid flush pass after any dropped rows.
// Assumes: each done input is a single-cycle pulse that arrives at least one
// cycle after the matching go; configuration is sampled at start.
module ccd_frame_seq
    import ccd_seq_pkg::*;
#(
    parameter int ROWS  = 330,
    parameter int INT_W = 24,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [ROW_W-1:0] cfg_row_first_i,
    input  logic [ROW_W-1:0] cfg_row_last_i,
    input  logic             cfg_bin2_i,
    input  logic             cfg_lowdark_i,
    input  logic [INT_W-1:0] cfg_integ_len_i,
    input  logic             vseq_done_i,
    input  logic             sseq_done_i,
    output logic             integ_o,
    output logic             vclk_low_o,
    output logic             vseq_go_o,
    output logic             ser_park_o,
    output logic             sseq_go_o,
    output logic             sseq_clear_o,
    output logic             line_valid_o,
    output logic [ROW_W-1:0] line_row_o,
    output logic             busy_o,
    output logic             frame_done_o
);
    seq_state_t       st, nxt;
    logic [ROW_W-1:0] first_q, last_q, grp_row, row;
    logic             bin2_q, lowdark_q, abort_q, dirty, bin_ph;
    logic             in_win, at_end, pair_ok, expired;
    logic             accept, abort_now, row_adv, pair_next;

    assign accept    = (st == ST_IDLE) && start_i;
    assign abort_now = abort_i || abort_q;
    assign pair_next = bin2_q && !bin_ph && pair_ok;

    ccd_integ_timer #(.CNT_W(INT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .len     (cfg_integ_len_i),
        .run     (st == ST_INTEG),
        .expired (expired)
    );

    ccd_row_track #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .adv     (row_adv),
        .first   (first_q),
        .last    (last_q),
        .row     (row),
        .in_win  (in_win),
        .at_end  (at_end),
        .pair_ok (pair_ok)
    );

    // Next-state decision of the frame sequence.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:       if (start_i) nxt = ST_INTEG;
            ST_INTEG:      if (abort_now) nxt = ST_IDLE;
                           else if (expired) nxt = ST_CLR_GO;
            ST_CLR_GO:     nxt = ST_CLR_WAIT;
            ST_CLR_WAIT:   if (sseq_done_i) nxt = abort_now ? ST_IDLE : ST_ROW;
            ST_ROW:        if (abort_now) nxt = ST_IDLE;
                           else if (!in_win) nxt = ST_DUMP_GO;
                           else if (dirty) nxt = ST_FLUSH_GO;
                           else nxt = ST_XFER_GO;
            ST_DUMP_GO:    nxt = ST_DUMP_WAIT;
            ST_DUMP_WAIT:  if (vseq_done_i)
                               nxt = abort_now ? ST_IDLE : (at_end ? ST_FIN : ST_ROW);
            ST_FLUSH_GO:   nxt = ST_FLUSH_WAIT;
            ST_FLUSH_WAIT: if (sseq_done_i) nxt = abort_now ? ST_IDLE : ST_XFER_GO;
            ST_XFER_GO:    nxt = ST_XFER_WAIT;
            ST_XFER_WAIT:  if (vseq_done_i)
                               nxt = abort_now ? ST_IDLE : (pair_next ? ST_XFER_GO : ST_READ_GO);
            ST_READ_GO:    nxt = ST_READ_WAIT;
            ST_READ_WAIT:  if (sseq_done_i)
                               nxt = abort_now ? ST_IDLE : (at_end ? ST_FIN : ST_ROW);
            ST_FIN:        nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // Row pointer moves after a drop, after the first row of a pair, or after a read.
    always_comb begin
        row_adv = 1'b0;
        if (st == ST_DUMP_WAIT && vseq_done_i && !at_end)
            row_adv = 1'b1;
        if (st == ST_XFER_WAIT && vseq_done_i && pair_next)
            row_adv = 1'b1;
        if (st == ST_READ_WAIT && sseq_done_i && !at_end)
            row_adv = 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // Configuration capture and pending abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= '0;
            last_q    <= '0;
            bin2_q    <= 1'b0;
            lowdark_q <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            if (accept) begin
                first_q   <= cfg_row_first_i;
                last_q    <= cfg_row_last_i;
                bin2_q    <= cfg_bin2_i;
                lowdark_q <= cfg_lowdark_i;
            end
            if (st == ST_IDLE)
                abort_q <= 1'b0;
            else if (abort_i)
                abort_q <= 1'b1;
        end
    end

    // Residual-charge flag, binning phase and line tagging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty        <= 1'b0;
            bin_ph       <= 1'b0;
            grp_row      <= '0;
            line_valid_o <= 1'b0;
            line_row_o   <= '0;
        end else begin
            line_valid_o <= 1'b0;
            if (accept) begin
                dirty  <= 1'b0;
                bin_ph <= 1'b0;
            end
            if (st == ST_DUMP_WAIT && vseq_done_i)
                dirty <= 1'b1;
            if (st == ST_FLUSH_WAIT && sseq_done_i)
                dirty <= 1'b0;
            if (st == ST_XFER_WAIT && vseq_done_i) begin
                if (!bin_ph)
                    grp_row <= row;
                bin_ph <= pair_next;
            end
            if (st == ST_READ_WAIT && sseq_done_i) begin
                line_valid_o <= 1'b1;
                line_row_o   <= grp_row;
                bin_ph       <= 1'b0;
            end
        end
    end

    // Output decode from the current state.
    always_comb begin
        integ_o      = (st == ST_INTEG);
        vclk_low_o   = (st == ST_INTEG) && lowdark_q;
        vseq_go_o    = (st == ST_DUMP_GO) || (st == ST_XFER_GO);
        ser_park_o   = (st == ST_DUMP_GO) || (st == ST_DUMP_WAIT);
        sseq_go_o    = (st == ST_CLR_GO) || (st == ST_FLUSH_GO) || (st == ST_READ_GO);
        sseq_clear_o = (st == ST_CLR_GO) || (st == ST_CLR_WAIT) ||
                       (st == ST_FLUSH_GO) || (st == ST_FLUSH_WAIT);
        busy_o       = (st != ST_IDLE);
        frame_done_o = (st == ST_FIN);
    end
endmodule

// File: rtl/ccd_frame_seq_chk.sv
// Protocol checker for the frame sequencer, attached by bind.
// Assumes: observes only top-level ports.
module ccd_frame_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic vseq_done_i,
    input logic sseq_done_i,
    input logic integ_o,
    input logic vclk_low_o,
    input logic vseq_go_o,
    input logic ser_park_o,
    input logic sseq_go_o,
    input logic sseq_clear_o,
    input logic line_valid_o,
    input logic busy_o,
    input logic frame_done_o
);
    p_vgo_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vseq_go_o |=> !vseq_go_o);
    p_sgo_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sseq_go_o |=> !sseq_go_o);
    p_vlow_in_integ_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vclk_low_o |-> integ_o);
    p_clear_after_integ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(integ_o) && busy_o) |-> (sseq_go_o && sseq_clear_o));
    p_park_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_park_o && !vseq_done_i) |=> ser_park_o);
    p_park_no_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_park_o |-> !line_valid_o);
    p_line_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> ($past(sseq_done_i) && !$past(sseq_clear_o)));
    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> (!busy_o && !frame_done_o));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!integ_o && !vseq_go_o && !sseq_go_o));
endmodule

bind ccd_frame_seq ccd_frame_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vseq_done_i  (vseq_done_i),
    .sseq_done_i  (sseq_done_i),
    .integ_o      (integ_o),
    .vclk_low_o   (vclk_low_o),
    .vseq_go_o    (vseq_go_o),
    .ser_park_o   (ser_park_o),
    .sseq_go_o    (sseq_go_o),
    .sseq_clear_o (sseq_clear_o),
    .line_valid_o (line_valid_o),
    .busy_o       (busy_o),
    .frame_done_o (frame_done_o)
);

// File: tb/sim_ccd_frame_seq.sv
`timescale 1ns/1ps
// Bench: models both sequencers with random done latency, logs issued pulses
// and compares them with an order computed from the requirements.
module sim_ccd_frame_seq;
    localparam int NROWS = 330;
    localparam int IW    = 24;
    localparam int RW    = $clog2(NROWS);
    localparam int LOGN  = 2048;

    // Event codes: 1 serial clear/flush, 2 parked vertical drop, 4 vertical
    // transfer, 6 serial read, 5 valid line (with row tag).
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
    logic [RW-1:0] cfg_first = '0, cfg_last = '0;
    logic cfg_bin2 = 1'b0, cfg_ld = 1'b0;
    logic [IW-1:0] cfg_len = '0;
    logic vdone = 1'b0, sdone = 1'b0;
    logic integ, vlow, vgo, park, sgo, sclr, lval, busy, fdone;
    logic [RW-1:0] lrow;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int obs_code [LOGN], obs_row [LOGN], exp_code [LOGN], exp_row [LOGN];
    int obs_n = 0, exp_n = 0, fd_cnt = 0, integ_cnt = 0, vlow_cnt = 0, go_after = 0;
    bit armed = 0;
    int vpend = 0, spend = 0;

    always #10 clk = ~clk;

    ccd_frame_seq #(.ROWS(NROWS), .INT_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .cfg_row_first_i(cfg_first), .cfg_row_last_i(cfg_last),
        .cfg_bin2_i(cfg_bin2), .cfg_lowdark_i(cfg_ld), .cfg_integ_len_i(cfg_len),
        .vseq_done_i(vdone), .sseq_done_i(sdone),
        .integ_o(integ), .vclk_low_o(vlow), .vseq_go_o(vgo), .ser_park_o(park),
        .sseq_go_o(sgo), .sseq_clear_o(sclr), .line_valid_o(lval),
        .line_row_o(lrow), .busy_o(busy), .frame_done_o(fdone)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Sequencer models: answer each go with one done pulse after 1..4 cycles.
    always @(negedge clk) begin
        vdone = 1'b0;
        sdone = 1'b0;
        if (vgo) vpend = 1 + int'($urandom % 4);
        else if (vpend > 0) begin vpend--; if (vpend == 0) vdone = 1'b1; end
        if (sgo) spend = 1 + int'($urandom % 4);
        else if (spend > 0) begin spend--; if (spend == 0) sdone = 1'b1; end
    end

    // Monitor: log pulses and count exposure and frame-done cycles.
    always @(negedge clk) begin
        if (obs_n < LOGN) begin
            if (sgo) begin obs_code[obs_n] = sclr ? 1 : 6; obs_row[obs_n] = 0; obs_n++; end
            if (vgo) begin obs_code[obs_n] = park ? 2 : 4; obs_row[obs_n] = 0; obs_n++; end
            if (lval) begin obs_code[obs_n] = 5; obs_row[obs_n] = int'(lrow); obs_n++; end
        end
        if (integ) integ_cnt++;
        if (vlow) vlow_cnt++;
        if (fdone) fd_cnt++;
        if (armed && (vgo || sgo)) go_after++;
    end

    task automatic push(int c, int r);
        exp_code[exp_n] = c; exp_row[exp_n] = r; exp_n++;
    endtask

    // Expected pulse order from R2..R7.
    task automatic fill_expected(int f, int l, bit b);
        int r = 0;
        bit dirty = 0;
        exp_n = 0;
        push(1, 0);
        while (r < NROWS) begin
            if (r < f || r > l) begin
                push(2, 0); dirty = 1; r++;
            end else begin
                int tag = r;
                if (dirty) begin push(1, 0); dirty = 0; end
                push(4, 0);
                if (b && r < l && r < NROWS - 1) begin r++; push(4, 0); end
                push(6, 0); push(5, tag); r++;
            end
        end
    endtask

    function automatic int count_code(bit use_obs, int c);
        int n = 0;
        int lim = use_obs ? obs_n : exp_n;
        for (int i = 0; i < lim; i++)
            if ((use_obs ? obs_code[i] : exp_code[i]) == c) n++;
        return n;
    endfunction

    task automatic clear_logs();
        @(posedge clk);
        obs_n = 0; fd_cnt = 0; integ_cnt = 0; vlow_cnt = 0; go_after = 0; armed = 0;
    endtask

    task automatic run_frame(int f, int l, bit b, bit m, int n, bit poke);
        int waited = 0;
        int mism = 0, mi = -1;
        int exp_int = (n < 1) ? 1 : n;
        @(negedge clk);
        cfg_first = RW'(f); cfg_last = RW'(l); cfg_bin2 = b; cfg_ld = m; cfg_len = IW'(n);
        fill_expected(f, l, b);
        clear_logs();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (fd_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            start = (poke && (waited == 40 || waited == 41)) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < obs_n && i < exp_n; i++)
            if (obs_code[i] != exp_code[i] || obs_row[i] != exp_row[i]) begin
                mism++; if (mi < 0) mi = i;
            end
        check(integ_cnt == exp_int, "R1", "exposure cycles", integ_cnt, exp_int);
        check(vlow_cnt == (m ? exp_int : 0), "R1", "vertical-low cycles", vlow_cnt, m ? exp_int : 0);
        check(obs_n > 0 && obs_code[0] == 1, "R2", "first pulse code", obs_n > 0 ? obs_code[0] : -1, 1);
        check(obs_n == exp_n && mism == 0, "R3", "pulse order (count / first bad index)",
              (obs_n == exp_n) ? mi : obs_n, (obs_n == exp_n) ? -1 : exp_n);
        check(count_code(1, 2) == count_code(0, 2), "R4", "parked drops", count_code(1, 2), count_code(0, 2));
        check(count_code(1, 1) == count_code(0, 1), "R5", "clear/flush passes", count_code(1, 1), count_code(0, 1));
        check(count_code(1, 5) == count_code(0, 5), b ? "R7" : "R6", "valid lines", count_code(1, 5), count_code(0, 5));
        check(fd_cnt == 1, "R8", "frame-done pulses", fd_cnt, 1);
        check(busy == 1'b0, "R8", "busy after done", int'(busy), 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            check(busy == 1'b0 && fd_cnt == 1, "R9", "restart after ignored start", int'(busy) + fd_cnt, 1);
        end
    endtask

    task automatic run_abort(int n, int delay);
        int waited = 0;
        @(negedge clk);
        cfg_first = RW'(10); cfg_last = RW'(200); cfg_bin2 = 1'b0; cfg_ld = 1'b1; cfg_len = IW'(n);
        clear_logs();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (delay) @(negedge clk);
        abort = 1'b1;
        @(posedge clk); #1 armed = 1;
        @(negedge clk) abort = 1'b0;
        while (busy && waited < 100) begin @(negedge clk); waited++; end
        repeat (20) @(negedge clk);
        check(go_after == 0, "R10", "go pulses after abort", go_after, 0);
        check(fd_cnt == 0, "R10", "frame-done after abort", fd_cnt, 0);
        check(busy == 1'b0, "R10", "busy after abort", int'(busy), 0);
        armed = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        check({integ, vlow, vgo, park, sgo, sclr, lval, busy, fdone} == '0 && lrow == '0,
              "R11", "outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({integ, vlow, vgo, park, sgo, sclr, lval, busy, fdone} == '0,
              "R11", "outputs after reset", int'(busy), 0);
        run_frame(0, NROWS - 1, 0, 1, 5, 0);     // full window, low-dark
        run_frame(100, 104, 1, 0, 0, 0);          // odd binned window, zero length
        run_frame(0, 0, 0, 0, 1, 0);              // single row at top
        run_frame(50, 20, 0, 1, 3, 0);            // empty window: all dropped
        run_frame(NROWS - 2, NROWS - 1, 1, 0, 2, 0); // binned pair at the bottom
        run_frame(NROWS - 1, NROWS - 1, 1, 1, 4, 1); // last row alone, start poked
        run_abort(1000, 10);                      // abort during exposure
        run_abort(2, 300);                        // abort during the row walk
        run_frame(7, 9, 1, 0, 3, 0);              // recovery after abort
        for (int k = 0; k < 4; k++) begin
            int f = int'($urandom % NROWS);
            int l = f + int'($urandom % 40) - 5;
            if (l > NROWS - 1) l = NROWS - 1;
            if (l < 0) l = 0;
            run_frame(f, l, 1'($urandom), 1'($urandom), int'($urandom % 20), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule